// File: doc/BRIEF.md
# Wait-Stated I/O Bus Slave

This block sits on a simple CPU I/O bus that has no bidirectional lines. The master marks each access with a one-cycle read or write strobe. It supplies a 32-bit byte address, four byte-lane enables and a 32-bit write data bus. The slave returns a 32-bit read data bus and a single ready pulse that ends the access.

The slave decodes two address windows. The first window is an on-chip synchronous memory. The memory registers the address on the strobe edge, so a read ends after two cycles and a write after one. The second window is a small register bank modelled as a slow external port. Every access to it, read or write, ends after a fixed number of wait states set by a parameter. An address outside both windows is answered after one cycle: a read returns zero and a write is dropped.

Only one access is outstanding at a time. A strobe is accepted only when the slave is idle. Strobes that arrive while an access is pending are discarded.

Top module: `io_slave_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, ready is low and read data is zero.
- R2: A write to the memory window (word i at MEM_BASE + 4*i, i < MEM_WORDS) raises ready exactly one cycle after the strobe cycle.
- R3: A read from the memory window raises ready exactly two cycles after the strobe cycle, and read data holds the addressed word in that cycle.
- R4: Any access to the slow window (word i at SLOW_BASE + 4*i, i < SLOW_WORDS) raises ready exactly WAIT_STATES cycles after the strobe cycle. A read there returns the stored word with ready.
- R5: Ready is high for a single cycle per accepted access. Read data is zero in every cycle where ready is low, and after a write.
- R6: Enable bit k (0..3) controls data bits 8k+7..8k. A lane whose enable bit is clear keeps its previous contents in either window.
- R7: A strobe seen from the cycle after acceptance through the ready cycle itself is ignored. It produces no ready and changes no stored word. A strobe in the cycle after ready is accepted.
- R8: An address outside both windows completes with ready one cycle after the strobe. A read there returns zero.
- R9: When both strobes are high in the same accepted cycle, the access is a read and the write data is discarded.
- R10: Address bits 1..0 are ignored for word selection. The first byte address past each window falls outside it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle read request |
| wr_stb | input | 1 | One-cycle write request |
| addr | input | 32 | Byte address of the access |
| be | input | 4 | Byte-lane enables for writes |
| wdata | input | 32 | Write data from the master |
| rdata | output | 32 | Read data, valid while ready is high |
| ready | output | 1 | One-cycle completion pulse |

## Verification
The stimulus fills both windows with full-word writes and then reads every word back. This separates the one-, two- and WAIT_STATES-cycle completion paths and shows that the two storage arrays are distinct. Partial-enable writes with each single lane and with mixed masks show which byte lanes are merged and which are kept. Three further groups of cycles target the control logic. Back-to-back strobes, strobes inside the pending window and strobes in the ready cycle exercise the acceptance rule. Accesses at the window edges and with low address bits set exercise the decoder. Simultaneous strobes and unmapped accesses confirm the read priority and the zero response.

// File: rtl/io_slave_pkg.sv
package io_slave_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_MEM  = 2'd1,
        RGN_SLOW = 2'd2
    } region_e;

    typedef struct packed {
        region_e     region;
        logic [29:0] word;
    } decode_t;

    typedef struct packed {
        region_e region;
        logic    is_rd;
    } pend_t;

    function automatic decode_t decode_addr(
        input logic [31:0] a,
        input logic [31:0] mem_base,
        input int unsigned mem_words,
        input logic [31:0] slow_base,
        input int unsigned slow_words
    );
        decode_t     d;
        logic [31:0] dm;
        logic [31:0] ds;
        dm = a - mem_base;
        ds = a - slow_base;
        d.region = RGN_NONE;
        d.word   = '0;
        if (a >= mem_base && (dm >> 2) < mem_words) begin
            d.region = RGN_MEM;
            d.word   = dm[31:2];
        end else if (a >= slow_base && (ds >> 2) < slow_words) begin
            d.region = RGN_SLOW;
            d.word   = ds[31:2];
        end
        return d;
    endfunction

    function automatic logic [31:0] lane_merge(
        input logic [31:0] old_w,
        input logic [31:0] new_w,
        input logic [3:0]  en
    );
        logic [31:0] r;
        for (int k = 0; k < 4; k++) begin
            r[8*k +: 8] = en[k] ? new_w[8*k +: 8] : old_w[8*k +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
    import io_slave_pkg::*;
#(
    parameter logic [31:0] MEM_BASE   = 32'h0000_0000,
    parameter int          MEM_WORDS  = 64,
    parameter logic [31:0] SLOW_BASE  = 32'h0000_1000,
    parameter int          SLOW_WORDS = 8,
    localparam int         MEM_AW     = $clog2(MEM_WORDS),
    localparam int         SLOW_AW    = $clog2(SLOW_WORDS)
) (
    input  logic [31:0]        addr,
    output region_e            region,
    output logic [MEM_AW-1:0]  mem_idx,
    output logic [SLOW_AW-1:0] slow_idx
);
    always_comb begin
        decode_t d;
        d        = decode_addr(addr, MEM_BASE, MEM_WORDS, SLOW_BASE, SLOW_WORDS);
        region   = d.region;
        mem_idx  = d.word[MEM_AW-1:0];
        slow_idx = d.word[SLOW_AW-1:0];
    end
endmodule

// File: rtl/io_byte_ram.sv
module io_byte_ram
    import io_slave_pkg::*;
#(
    parameter int  WORDS = 64,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] idx,
    input  logic [3:0]    be,
    input  logic [31:0]   wd,
    output logic [31:0]   q
);
    logic [31:0] store [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            store[idx] <= lane_merge(store[idx], wd, be);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (re) begin
            q <= store[idx];
        end
    end
endmodule

// File: rtl/io_wait_timer.sv
module io_wait_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] lat,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= lat - 1'b1;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/io_slave_top.sv
module io_slave_top
    import io_slave_pkg::*;
#(
    parameter logic [31:0] MEM_BASE    = 32'h0000_0000,
    parameter int          MEM_WORDS   = 64,
    parameter logic [31:0] SLOW_BASE   = 32'h0000_1000,
    parameter int          SLOW_WORDS  = 8,
    parameter int          WAIT_STATES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_stb,
    input  logic        wr_stb,
    input  logic [31:0] addr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        ready
);
    localparam int MEM_AW  = $clog2(MEM_WORDS);
    localparam int SLOW_AW = $clog2(SLOW_WORDS);
    localparam int CW      = $clog2(WAIT_STATES + 1) + 1;

    region_e            region;
    logic [MEM_AW-1:0]  mem_idx;
    logic [SLOW_AW-1:0] slow_idx;
    logic               busy;
    logic               accept;
    logic               is_rd;
    logic [CW-1:0]      lat;
    pend_t              pend;
    logic [31:0]        mem_q;
    logic [31:0]        slow_q;

    io_addr_decode #(
        .MEM_BASE  (MEM_BASE),
        .MEM_WORDS (MEM_WORDS),
        .SLOW_BASE (SLOW_BASE),
        .SLOW_WORDS(SLOW_WORDS)
    ) u_dec (
        .addr    (addr),
        .region  (region),
        .mem_idx (mem_idx),
        .slow_idx(slow_idx)
    );

    assign accept = (rd_stb || wr_stb) && !busy;
    assign is_rd  = rd_stb;

    always_comb begin
        unique case (region)
            RGN_MEM:  lat = is_rd ? CW'(2) : CW'(1);
            RGN_SLOW: lat = CW'(WAIT_STATES);
            default:  lat = CW'(1);
        endcase
    end

    io_wait_timer #(.CW(CW)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .start(accept),
        .lat  (lat),
        .busy (busy),
        .done (ready)
    );

    io_byte_ram #(.WORDS(MEM_WORDS)) u_mem (
        .clk(clk),
        .rst(rst),
        .we (accept && !is_rd && region == RGN_MEM),
        .re (accept && is_rd && region == RGN_MEM),
        .idx(mem_idx),
        .be (be),
        .wd (wdata),
        .q  (mem_q)
    );

    io_byte_ram #(.WORDS(SLOW_WORDS)) u_slow (
        .clk(clk),
        .rst(rst),
        .we (accept && !is_rd && region == RGN_SLOW),
        .re (accept && is_rd && region == RGN_SLOW),
        .idx(slow_idx),
        .be (be),
        .wd (wdata),
        .q  (slow_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '{region: RGN_NONE, is_rd: 1'b0};
        end else if (accept) begin
            pend <= '{region: region, is_rd: is_rd};
        end
    end

    always_comb begin
        rdata = '0;
        if (ready && pend.is_rd) begin
            unique case (pend.region)
                RGN_MEM:  rdata = mem_q;
                RGN_SLOW: rdata = slow_q;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/io_slave_chk.sv
module io_slave_chk #(
    parameter logic [31:0] MEM_BASE    = 32'h0000_0000,
    parameter int          MEM_WORDS   = 64,
    parameter logic [31:0] SLOW_BASE   = 32'h0000_1000,
    parameter int          SLOW_WORDS  = 8,
    parameter int          WAIT_STATES = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic [31:0] addr,
    input logic [31:0] rdata,
    input logic        ready
);
    logic        c_pend;
    logic [15:0] c_cnt;
    logic [15:0] c_lat;
    logic        c_unm_rd;
    logic        in_mem;
    logic        in_slow;
    logic [15:0] want_lat;

    assign in_mem  = (addr >= MEM_BASE) && (addr < MEM_BASE + 32'(MEM_WORDS * 4));
    assign in_slow = (addr >= SLOW_BASE) && (addr < SLOW_BASE + 32'(SLOW_WORDS * 4));
    assign want_lat = in_mem ? (rd_stb ? 16'd2 : 16'd1)
                    : in_slow ? 16'(WAIT_STATES) : 16'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_pend   <= 1'b0;
            c_cnt    <= '0;
            c_lat    <= '0;
            c_unm_rd <= 1'b0;
        end else if (!c_pend && (rd_stb || wr_stb)) begin
            c_pend   <= 1'b1;
            c_cnt    <= 16'd1;
            c_lat    <= want_lat;
            c_unm_rd <= rd_stb && !in_mem && !in_slow;
        end else if (c_pend) begin
            if (c_cnt == c_lat) begin
                c_pend <= 1'b0;
            end else begin
                c_cnt <= c_cnt + 16'd1;
            end
        end
    end

    initial begin
        assert_wait_min_R4: assert (WAIT_STATES >= 2 && WAIT_STATES < 65535);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !ready);

    // R3, R4 also: ready only at the counted latency of an accepted access
    assert_ready_timing_R2: assert property (@(posedge clk) disable iff (rst)
        ready |-> (c_pend && c_cnt == c_lat));

    assert_ready_due_R7: assert property (@(posedge clk) disable iff (rst)
        (c_pend && c_cnt == c_lat) |-> ready);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (rdata == 32'h0));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (ready && c_unm_rd) |-> (rdata == 32'h0));
endmodule

bind io_slave_top io_slave_chk #(
    .MEM_BASE   (MEM_BASE),
    .MEM_WORDS  (MEM_WORDS),
    .SLOW_BASE  (SLOW_BASE),
    .SLOW_WORDS (SLOW_WORDS),
    .WAIT_STATES(WAIT_STATES)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .rd_stb(rd_stb),
    .wr_stb(wr_stb),
    .addr  (addr),
    .rdata (rdata),
    .ready (ready)
);

// File: tb/sim_io_slave_top.sv
module sim_io_slave_top;
    localparam logic [31:0] MB = 32'h0000_0000;
    localparam int          MW = 64;
    localparam logic [31:0] SB = 32'h0000_1000;
    localparam int          SW = 8;
    localparam int          WS = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_stb, wr_stb;
    logic [31:0] addr, wdata, rdata;
    logic [3:0]  be;
    logic        ready;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural reference state
    logic [31:0] m_mem  [MW];
    logic [31:0] m_slow [SW];
    bit          m_busy;
    int          m_cnt;
    bit          m_rd;
    logic [31:0] m_data;

    always #2 clk = ~clk;

    io_slave_top #(
        .MEM_BASE(MB), .MEM_WORDS(MW), .SLOW_BASE(SB),
        .SLOW_WORDS(SW), .WAIT_STATES(WS)
    ) u0 (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .addr(addr), .be(be), .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] e);
        logic [31:0] r = o;
        for (int k = 0; k < 4; k++) if (e[k]) r[8*k +: 8] = n[8*k +: 8];
        return r;
    endfunction

    task automatic model_edge();
        int lat;
        longint unsigned a;
        a = longint'(addr);
        if (rst) begin
            m_busy = 0;
        end else if (m_busy) begin
            if (m_cnt == 0) m_busy = 0;
            else m_cnt--;
        end else if (rd_stb || wr_stb) begin
            m_rd   = rd_stb;
            m_data = 32'h0;
            if (a >= MB && a < MB + MW * 4) begin
                lat = m_rd ? 2 : 1;
                if (m_rd) m_data = m_mem[(a - MB) / 4];
                else m_mem[(a - MB) / 4] = merge(m_mem[(a - MB) / 4], wdata, be);
            end else if (a >= SB && a < SB + SW * 4) begin
                lat = WS;
                if (m_rd) m_data = m_slow[(a - SB) / 4];
                else m_slow[(a - SB) / 4] = merge(m_slow[(a - SB) / 4], wdata, be);
            end else begin
                lat = 1;
            end
            m_busy = 1;
            m_cnt  = lat - 1;
        end
    endtask

    task automatic compare();
        logic        e_rdy;
        logic [31:0] e_dat;
        e_rdy = m_busy && m_cnt == 0 && !rst;
        e_dat = (e_rdy && m_rd) ? m_data : 32'h0;
        checks++;
        if (ready !== e_rdy || rdata !== e_dat) begin
            fails++;
            $display("FAIL %s: ready=%0b rdata=%08h expected ready=%0b rdata=%08h",
                     tag, ready, rdata, e_rdy, e_dat);
        end
    endtask

    task automatic tick(input logic r, input logic w, input logic [31:0] a,
                        input logic [3:0] e, input logic [31:0] d);
        rd_stb = r; wr_stb = w; addr = a; be = e; wdata = d;
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 32'h0, 4'h0, 32'h0);
    endtask

    task automatic wr(input logic [31:0] a, input logic [3:0] e, input logic [31:0] d);
        tick(0, 1, a, e, d);
        idle(WS + 1);
    endtask

    task automatic rd(input logic [31:0] a);
        tick(1, 0, a, 4'h0, 32'h0);
        idle(WS + 1);
    endtask

    initial begin
        rst = 1'b1; rd_stb = 0; wr_stb = 0; addr = 0; be = 0; wdata = 0;
        m_busy = 0; m_cnt = 0; m_rd = 0; m_data = 0;
        @(negedge clk);
        tag = "R1";
        for (int i = 0; i < 3; i++) tick(1, 1, MB, 4'hF, 32'hFFFF_FFFF);
        rst = 1'b0;
        idle(2);

        tag = "R2";
        for (int i = 0; i < MW; i++) wr(MB + 4 * i, 4'hF, 32'hA500_0000 + i * 32'h0101_0103);
        tag = "R4";
        for (int i = 0; i < SW; i++) wr(SB + 4 * i, 4'hF, 32'h5A00_0000 ^ (i * 32'h1357_9BDF));
        tag = "R3";
        for (int i = 0; i < MW; i++) rd(MB + 4 * i);
        tag = "R4";
        for (int i = 0; i < SW; i++) rd(SB + 4 * i);

        tag = "R6";
        for (int k = 0; k < 4; k++) begin
            wr(MB + 4 * k, 4'(1 << k), 32'hC3C3_C3C3);
            rd(MB + 4 * k);
        end
        wr(MB + 40, 4'b1010, 32'h1122_3344); rd(MB + 40);
        wr(MB + 44, 4'b0000, 32'hDEAD_BEEF); rd(MB + 44);
        wr(SB + 8, 4'b0101, 32'h0F0F_0F0F); rd(SB + 8);

        tag = "R10";
        rd(MB + 4 * 5 + 3);
        wr(MB + 4 * 6 + 2, 4'hF, 32'h6666_0006); rd(MB + 4 * 6 + 1);
        rd(MB + 4 * (MW - 1));
        rd(MB + 4 * MW);
        rd(SB + 4 * (SW - 1) + 1);
        rd(SB + 4 * SW);
        rd(SB - 4);

        tag = "R8";
        rd(32'h8000_0000);
        wr(32'h8000_0000, 4'hF, 32'h1234_5678);
        rd(32'hFFFF_FFFC);

        tag = "R7";
        tick(1, 0, SB + 4, 4'h0, 32'h0);
        for (int i = 0; i < WS; i++) tick(0, 1, SB + 4, 4'hF, 32'hBAD0_0000 + i);
        tick(1, 0, MB + 8, 4'h0, 32'h0);
        tick(0, 1, MB + 8, 4'hF, 32'hBAD1_1111);
        tick(0, 1, MB + 8, 4'hF, 32'hBAD2_2222);
        idle(2);
        rd(SB + 4);
        rd(MB + 8);

        tag = "R5";
        tick(0, 1, MB + 12, 4'hF, 32'h0000_1212);
        tick(1, 0, MB + 12, 4'h0, 32'h0);
        tick(0, 0, 32'h0, 4'h0, 32'h0);
        tick(0, 0, 32'h0, 4'h0, 32'h0);
        tick(1, 0, 32'h4000_0000, 4'h0, 32'h0);
        tick(0, 0, 32'h0, 4'h0, 32'h0);
        tick(1, 0, MB + 12, 4'h0, 32'h0);
        idle(4);

        tag = "R9";
        tick(1, 1, MB + 16, 4'hF, 32'h9999_9999);
        idle(3);
        rd(MB + 16);
        tick(1, 1, SB + 12, 4'hF, 32'h8888_8888);
        idle(WS + 1);
        rd(SB + 12);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected completion before %0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule